// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of a small serial memory that answers on a two-wire I2C bus. It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It compares the incoming device address with a fixed type code plus three strap pins. It then carries out single-byte writes and sequential reads against an internal byte array.

A write carries a two-byte word address, high byte first, followed by one data byte. That byte is held until the master closes the transaction with STOP. The STOP launches a programming interval of a programmable number of system clocks, and the byte lands in the array when the interval ends. Throughout that interval the block is deaf to the bus. A read streams bytes from an internal pointer, which advances after every byte and wraps at the top of the array. The stream continues for as long as the master acknowledges.

Top module: `ee_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including in the middle of a transaction, restarts reception of the device address.
- R2: The device address byte is sent MSB first. It is bits[7:4]=1010, bits[3:1]=sel_i[2:0], then bit0 = direction (1 = read). On a match the slave pulls SDA low during the ninth SCL clock. On a mismatch SDA stays released, with no acknowledge and no data, until the next START.
- R3: In a write every byte is acknowledged. The second and third bytes form the word address, high byte first. The pointer is set to that address modulo the array depth (64 bytes by default).
- R4: The data byte of a write is held pending. Further data bytes in the same transaction are acknowledged and replace it. A STOP launches a programming interval of PROG_CYCLES clocks, and the array is updated only when that interval ends. A repeated START discards the pending byte, so nothing is programmed and no interval starts.
- R5: During the programming interval the slave ignores all bus traffic, including its own address: SDA stays released.
- R6: A read sends the byte at the pointer, MSB first, with each bit changed after SCL falls. The slave releases SDA in the ninth clock. The pointer advances by one after each byte sent and wraps from the top of the array to 0.
- R7: If the master pulls SDA low in the ninth clock of a read byte, the slave sends the next byte. If the master leaves SDA high, the slave stops driving and keeps SDA released until the next STOP or START.
- R8: A read addressed with no preceding word-address bytes starts at the current pointer. That pointer is the value left by the last address load or read; a write does not move it.
- R9: After reset SDA is released, the pointer is 0, every array byte is 8'hFF and no programming interval is running.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sel_i | input | 3 | Strap pins forming device address bits 3:1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The end of the programming interval, when the array byte is written and the busy state drops, can fall in the same cycle as a START detected on the bus. The bench writes a byte and then issues a current-address read at a sweep of delays that straddle the end of the interval. Each attempt is judged as follows: a NACK is accepted, and an acknowledged read must return the newly written byte, never the old one. The sweep must also produce both outcomes.

// File: rtl/ee_slv_pkg.sv
// Shared types and constants for the two-wire memory slave.
// Assumes: nothing beyond IEEE 1800-2017.
package ee_slv_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_LOAD,
        ST_WAIT
    } eng_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_t;
endpackage

// File: rtl/ee_slv_sync.sv
// Line conditioner: brings SCL and SDA into the clock domain through a
// SYNC_STAGES-deep flop chain, then flags SCL edges and START/STOP.
// Assumes the bus is much slower than clk (several clocks per SCL phase).
module ee_slv_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift both lines through the synchronizer; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
            scl_prev  <= scl_chain[SYNC_STAGES-1];
            sda_prev  <= sda_chain[SYNC_STAGES-1];
        end
    end

    assign scl_lvl = scl_chain[SYNC_STAGES-1];
    assign sda_lvl = sda_chain[SYNC_STAGES-1];

    // Edge and bus-condition flags, one clock wide each.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/ee_slv_engine.sv
// Protocol engine: receives bytes, matches the device address, loads the
// word pointer, holds a pending write byte, streams read bytes and drives
// the SDA pull-down for acknowledges and data.
// Assumes conditioned line flags from ee_slv_sync and a combinational read
// port on the store; while busy_i is high the engine is held idle.
module ee_slv_engine
    import ee_slv_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        sel_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic [MEM_AW-1:0] rd_addr_o,
    output logic              commit_o,
    output logic [MEM_AW-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              sda_pull_o
);
    eng_state_t        state;
    rx_kind_t          kind;
    logic [3:0]        bitcnt;
    logic [7:0]        rxsh;
    logic [7:0]        txsh;
    logic              go_tx;
    logic [7:0]        addr_hi;
    logic [15:0]       ptr;
    logic              wr_pend;
    logic [MEM_AW-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              pull;

    // Main bus sequencer; busy, START and STOP take priority over the byte flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= K_DEV;
            bitcnt  <= '0;
            rxsh    <= '0;
            txsh    <= '0;
            go_tx   <= 1'b0;
            addr_hi <= '0;
            ptr     <= '0;
            wr_pend <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            pull    <= 1'b0;
        end else if (busy_i) begin
            state   <= ST_IDLE;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
        end else if (start_i) begin
            state   <= ST_RX;
            kind    <= K_DEV;
            bitcnt  <= '0;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
        end else if (stop_i) begin
            state   <= ST_IDLE;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise_i && bitcnt != 4'd8) begin
                        rxsh   <= {rxsh[6:0], sda_lvl_i};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall_i && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        case (kind)
                            K_DEV: begin
                                if (rxsh[7:1] == {DEV_TYPE, sel_i}) begin
                                    pull  <= 1'b1;
                                    state <= ST_RX_ACK;
                                    go_tx <= rxsh[0];
                                    kind  <= K_AHI;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            K_AHI: begin
                                addr_hi <= rxsh;
                                pull    <= 1'b1;
                                state   <= ST_RX_ACK;
                                go_tx   <= 1'b0;
                                kind    <= K_ALO;
                            end
                            K_ALO: begin
                                ptr   <= {addr_hi, rxsh};
                                pull  <= 1'b1;
                                state <= ST_RX_ACK;
                                go_tx <= 1'b0;
                                kind  <= K_DATA;
                            end
                            default: begin
                                wr_pend <= 1'b1;
                                wr_addr <= ptr[MEM_AW-1:0];
                                wr_data <= rxsh;
                                pull    <= 1'b1;
                                state   <= ST_RX_ACK;
                                go_tx   <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        if (go_tx) begin
                            txsh  <= rd_data_i;
                            pull  <= ~rd_data_i[7];
                            state <= ST_TX;
                        end else begin
                            pull  <= 1'b0;
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall_i && bitcnt != 4'd0) begin
                        if (bitcnt == 4'd8) begin
                            pull   <= 1'b0;
                            state  <= ST_TX_ACK;
                            ptr    <= ptr + 16'd1;
                            bitcnt <= '0;
                        end else begin
                            txsh <= {txsh[6:0], 1'b0};
                            pull <= ~txsh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        state <= sda_lvl_i ? ST_WAIT : ST_TX_LOAD;
                    end
                end
                ST_TX_LOAD: begin
                    if (scl_fall_i) begin
                        txsh  <= rd_data_i;
                        pull  <= ~rd_data_i[7];
                        state <= ST_TX;
                    end
                end
                default: begin
                    pull <= 1'b0;
                end
            endcase
        end
    end

    assign rd_addr_o  = ptr[MEM_AW-1:0];
    assign wr_addr_o  = wr_addr;
    assign wr_data_o  = wr_data;
    assign sda_pull_o = pull;
    // A held byte is handed to the store on the STOP that closes its write.
    assign commit_o   = stop_i & wr_pend & ~busy_i;

    // Drive changes only while SCL is low, bus conditions aside.
    assert_sda_only_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl_i && $past(scl_lvl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(pull));
    // Deaf while programming.
    assert_silent_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> !pull);
    // SDA released for the master's acknowledge slot.
    assert_release_for_mack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !pull);
    // Mismatched or abandoned transfers keep the line free.
    assert_wait_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !pull);
    // Pointer advances by one on every byte sent.
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TX && state == ST_TX_ACK) |-> ptr == $past(ptr) + 16'd1);
endmodule

// File: rtl/ee_slv_store.sv
// Byte array plus programming timer. A commit latches address and data,
// runs PROG_CYCLES clocks of busy, and writes the array on the last one.
// Assumes commits arrive only while not busy.
module ee_slv_store #(
    parameter int MEM_AW      = 6,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [MEM_AW-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int CW    = $clog2(PROG_CYCLES + 1);

    logic [7:0]        mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [MEM_AW-1:0] lat_addr;
    logic [7:0]        lat_data;

    // Programming timer and latched write; array written on the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (commit_i && cnt == '0) begin
            cnt      <= CW'(PROG_CYCLES);
            lat_addr <= wr_addr_i;
            lat_data <= wr_data_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                mem[lat_addr] <= lat_data;
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign busy_o    = (cnt != '0);

    // Engine must not hand over a byte during programming.
    assert_no_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !busy_o);
    // A commit always opens a programming interval.
    assert_commit_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> busy_o);
endmodule

// File: rtl/ee_i2c_slave.sv
// Top of the two-wire memory slave: conditioner, protocol engine and
// byte store with programming timer. Open-drain output: sda_pull_o=1
// pulls the line low. Assumes SCL phases last several clk periods.
module ee_i2c_slave #(
    parameter int MEM_AW      = 6,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] sel_i,
    output logic       sda_pull_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, commit;
    logic [7:0]        rd_data, wr_data;
    logic [MEM_AW-1:0] rd_addr, wr_addr;

    ee_slv_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    ee_slv_engine #(.MEM_AW(MEM_AW)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det),
        .stop_i(stop_det), .sel_i(sel_i), .busy_i(busy), .rd_data_i(rd_data),
        .rd_addr_o(rd_addr), .commit_o(commit), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .sda_pull_o(sda_pull_o)
    );

    ee_slv_store #(.MEM_AW(MEM_AW), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .busy_o(busy)
    );
endmodule

// File: tb/ee_i2c_slave_tb.sv
module ee_i2c_slave_tb;
    localparam int PROG  = 400;
    localparam int Q     = 6;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic sda_pull;
    wire  sda_bus = sda_m & ~sda_pull;

    int checks = 0;
    int failures = 0;
    int r10_bad = 0;
    logic [7:0] exp_mem [DEPTH];
    int mptr = 0;

    always #4 clk = ~clk;

    ee_i2c_slave #(.MEM_AW(6), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sel_i(sel), .sda_pull_o(sda_pull)
    );

    // R10 monitor: drive must not change while SCL is held high.
    logic scl_q = 1'b1, pull_q = 1'b0;
    always @(posedge clk) begin
        if (rst_n && scl_m && scl_q && sda_pull != pull_q) r10_bad++;
        scl_q  <= scl_m;
        pull_q <= sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(1);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); ack = ~sda_bus; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl_m = 1'b1; wq(1); b[i] = sda_bus; wq(1); scl_m = 1'b0;
        end
        wq(1); sda_m = ~mack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic ee_write(input logic [15:0] a, input logic [7:0] d, input string req);
        logic k0, k1, k2, k3;
        bus_start();
        wbyte(dev(0), k0); wbyte(a[15:8], k1); wbyte(a[7:0], k2); wbyte(d, k3);
        bus_stop();
        chk(k0 && k1 && k2 && k3, req, {k0, k1, k2, k3}, 4'hF);
        exp_mem[a % DEPTH] = d;
        mptr = a % DEPTH;
    endtask

    task automatic ee_read(input logic [15:0] a, input int n, input string req);
        logic k0, k1, k2, k3;
        logic [7:0] b;
        bus_start();
        wbyte(dev(0), k0); wbyte(a[15:8], k1); wbyte(a[7:0], k2);
        bus_start();
        wbyte(dev(1), k3);
        chk(k0 && k1 && k2 && k3, {req, " addr ack"}, {k0, k1, k2, k3}, 4'hF);
        mptr = a % DEPTH;
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, b);
            chk(b == exp_mem[mptr], req, b, exp_mem[mptr]);
            mptr = (mptr + 1) % DEPTH;
        end
        bus_stop();
    endtask

    initial begin
        logic ack, k1, k2;
        logic [7:0] b;
        int acked = 0, nacked = 0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: reset state
        chk(sda_pull == 1'b0, "R9 sda released", sda_pull, 0);
        // R8/R9: current-address read right after reset
        bus_start(); wbyte(dev(1), ack);
        chk(ack, "R2 match ack", ack, 1);
        rbyte(0, b); bus_stop();
        chk(b == 8'hFF, "R9 R8 first byte", b, 8'hFF);
        mptr = 1;

        // R3/R5/R4: write then hammer during programming
        ee_write(16'h0005, 8'h3C, "R3 write acks");
        bus_start(); wbyte(dev(0), ack);
        chk(!ack, "R5 busy nack", ack, 0);
        wbyte(8'h00, ack);
        chk(!ack, "R5 busy stays silent", ack, 0);
        bus_stop();
        repeat (PROG + 50) @(negedge clk);
        ee_read(16'h0005, 1, "R4 programmed value");

        // R6/R3: wrap at top, high address bits folded away
        ee_write(16'h003F, 8'hA5, "R3 write top");
        repeat (PROG + 50) @(negedge clk);
        ee_read(16'hFF3F, 3, "R6 wrap read");

        // R7: master NACK then slave silent
        bus_start(); wbyte(dev(1), ack);
        rbyte(0, b);
        chk(b == exp_mem[mptr], "R8 current read", b, exp_mem[mptr]);
        mptr = (mptr + 1) % DEPTH;
        rbyte(0, b);
        chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
        bus_stop();

        // R2: wrong strap bits
        bus_start(); wbyte({4'b1010, sel ^ 3'b010, 1'b0}, ack);
        chk(!ack, "R2 mismatch nack", ack, 0);
        wbyte(8'h00, ack);
        chk(!ack, "R2 mismatch silent", ack, 0);
        bus_stop();

        // R4: extra data bytes replace the held one
        bus_start(); wbyte(dev(0), ack); wbyte(8'h12, ack); wbyte(8'h20, ack);
        wbyte(8'h77, k1); wbyte(8'h99, k2); bus_stop();
        chk(k1 && k2, "R4 extra byte ack", {k1, k2}, 2'b11);
        exp_mem[8'h20] = 8'h99;
        repeat (PROG + 50) @(negedge clk);
        ee_read(16'h1220, 1, "R4 last byte wins");

        // R1/R4: repeated START discards the held byte, no busy follows
        bus_start(); wbyte(dev(0), ack); wbyte(8'h00, ack); wbyte(8'h07, ack);
        wbyte(8'h5A, ack);
        bus_start(); wbyte(dev(1), ack);
        chk(ack, "R1 restart ack not busy", ack, 1);
        rbyte(0, b); bus_stop();
        chk(b == exp_mem[7], "R4 discarded write", b, exp_mem[7]);
        mptr = 8;

        // Random writes and sequential reads
        for (int it = 0; it < 16; it++) begin
            logic [15:0] a = 16'($urandom);
            logic [7:0]  d = 8'($urandom);
            int n = 1 + ($urandom % 4);
            ee_write(a, d, "R3 rand write");
            repeat (PROG + 50) @(negedge clk);
            ee_read(16'($urandom), n, "R6 rand read");
        end

        // Sweep START across the end of programming
        for (int k = 0; k < 10; k++) begin
            logic [7:0] nd = 8'h40 + 8'(k);
            ee_write(16'h000A, nd, "R3 sweep write");
            repeat (PROG - 40 + k * 8) @(negedge clk);
            bus_start(); wbyte(dev(1), ack);
            if (ack) begin
                acked++;
                rbyte(0, b);
                chk(b == nd, "R4 R5 sweep new data", b, nd);
            end else begin
                nacked++;
            end
            bus_stop();
            repeat (PROG + 50) @(negedge clk);
        end
        chk(acked > 0 && nacked > 0, "R5 sweep both outcomes", {acked[7:0], nacked[7:0]}, 0);

        chk(r10_bad == 0, "R10 drive only with SCL low", r10_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule